// File: doc/BRIEF.md
# Dual-Rail Four-Phase Pipeline Emulator

This block is a clocked model of a linear self-timed pipeline. Each stage exchanges dual-rail words with its neighbours over a four-phase return-to-zero handshake. A word is valid when every bit has exactly one rail high, and it is neutral when all rails are low. The receiver raises its acknowledge once it has captured a valid word and lowers it once the sender has returned to neutral. Each stage updates only from the values its neighbours held in the previous clock step, so there is no combinational loop anywhere in the chain.

A build parameter selects how a stage orders its reset phase. In half-buffer mode, a stage keeps its output word until its own input has gone neutral, so two adjacent stages can never hold different words. In full-buffer mode, a stage clears its output as soon as the next stage acknowledges, whatever its input is doing. This choice sets the pipeline's capacity to N/2 words or to N words. The block reports which stages hold unaccepted words and how many such words there are. It also raises a sticky flag when an input bit has both rails high.

Top module: `dr_pipe`

## Requirements
- R1: While reset is low at a clock edge, and after that edge, all output rails, in_ack, every occ bit, occ_count and proto_err are zero.
- R2: Bit k of a word has value 1 when t[k]=1 and f[k]=0, value 0 when t[k]=0 and f[k]=1, and is neutral when both are 0. Every word accepted at the input leaves at the output unchanged and in the same order.
- R3: A stage captures a word only when every bit is valid. A partly valid word gets no acknowledge and occupies no stage.
- R4: in_ack rises only after a complete valid word is present, stays high while that word is held valid, and falls only after the input has returned to neutral.
- R5: With MODE = half-buffer and the consumer stalled, the pipeline holds at most N_STAGES/2 words. For even N_STAGES it reaches exactly that, with the occupied stages being the odd-numbered ones (bit pattern ...1010).
- R6: With MODE = full-buffer and the consumer stalled, all N_STAGES stages each hold a distinct word (occ all ones).
- R7: occ[i] is high when stage i (stage 0 nearest the input) drives a valid word that its downstream neighbour has not yet acknowledged. occ_count equals the number of set occ bits.
- R8: An input bit with both rails high is never accepted. It sets proto_err one edge later, and proto_err stays high until reset.
- R9: While out_ack is low, a valid output word is held stable. The output rails return to neutral only after out_ack has been high.
- R10: With an empty pipeline and a valid word applied before a clock edge, the word appears at the output after exactly N_STAGES edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Emulation step clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_t | input | WIDTH | True rails of the input channel |
| in_f | input | WIDTH | False rails of the input channel |
| in_ack | output | 1 | Acknowledge to the producer |
| out_t | output | WIDTH | True rails of the output channel |
| out_f | output | WIDTH | False rails of the output channel |
| out_ack | input | 1 | Acknowledge from the consumer |
| occ | output | N_STAGES | Per-stage unaccepted-word flags |
| occ_count | output | $clog2(N_STAGES+1) | Number of words held |
| proto_err | output | 1 | Sticky illegal-rail flag |

## Verification
The bench stalls the consumer and checks the exact occupancy pattern each mode settles into. A half-buffer design that cleared its output too early would fill every stage. A full-buffer design that waited for its input to go neutral would stop at half capacity. Partly valid and illegal words are applied at the input and the bench confirms that no acknowledge follows. A completion check that tested any single bit, instead of every bit, would capture a half-formed word. The bench also streams every 4-bit value through both modes, with and without backpressure, to catch reordering, duplicated words, and output rails that change before out_ack.

// File: rtl/dr_pkg.sv
// Package: shared types for the dual-rail pipeline emulator.
// Assumes: nothing beyond IEEE 1800-2017.
package dr_pkg;

    // Reset-phase ordering chosen at build time.
    typedef enum logic {
        MODE_HALF = 1'b0,   // output clears only after input is neutral
        MODE_FULL = 1'b1    // output clears as soon as it is acknowledged
    } buf_mode_e;

endpackage

// File: rtl/dr_compl.sv
// Module: completion detector for one dual-rail word.
// Does: reports whether every bit is valid, whether all rails are low,
// and whether any bit has both rails high.
// Assumes: purely combinational, no state.
module dr_compl #(
    parameter int WIDTH = 2
) (
    input  logic [WIDTH-1:0] rail_t,
    input  logic [WIDTH-1:0] rail_f,
    output logic             all_valid,
    output logic             all_neutral,
    output logic             any_illegal
);

    logic [WIDTH-1:0] bit_ok;
    logic [WIDTH-1:0] bit_off;
    logic [WIDTH-1:0] bit_bad;

    // Per-bit classification of the rail pair.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign bit_ok[b]  = rail_t[b] ^ rail_f[b];
        assign bit_off[b] = ~(rail_t[b] | rail_f[b]);
        assign bit_bad[b] = rail_t[b] & rail_f[b];
    end

    // Word-level completion: every bit must agree.
    assign all_valid   = &bit_ok;
    assign all_neutral = &bit_off;
    assign any_illegal = |bit_bad;

endmodule

// File: rtl/dr_stage.sv
// Module: one emulated handshake stage.
// Does: captures a complete dual-rail word from the left channel when the
// right channel is idle, acknowledges left, and returns its output to neutral
// according to the selected reset ordering. Acknowledge and output hold their
// values unless a set or clear condition holds, in the manner of a C-element.
// Assumes: inputs are the neighbours' registered values from the prior step.
module dr_stage
    import dr_pkg::*;
#(
    parameter int        WIDTH = 2,
    parameter buf_mode_e MODE  = MODE_HALF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] l_t,
    input  logic [WIDTH-1:0] l_f,
    input  logic             r_ack,
    output logic [WIDTH-1:0] r_t,
    output logic [WIDTH-1:0] r_f,
    output logic             l_ack,
    output logic             occ,
    output logic             l_illegal
);

    logic [WIDTH-1:0] rt_q, rf_q;
    logic             ack_q;
    logic             l_valid, l_neutral;
    logic             r_valid, r_neutral, r_bad;
    logic             fire, drop_r, drop_a;

    dr_compl #(.WIDTH(WIDTH)) u_lc (
        .rail_t(l_t), .rail_f(l_f),
        .all_valid(l_valid), .all_neutral(l_neutral), .any_illegal(l_illegal)
    );

    dr_compl #(.WIDTH(WIDTH)) u_rc (
        .rail_t(rt_q), .rail_f(rf_q),
        .all_valid(r_valid), .all_neutral(r_neutral), .any_illegal(r_bad)
    );

    // Capture condition: full word in, previous handshake closed, right idle.
    assign fire = l_valid & ~ack_q & ~r_ack & r_neutral;

    // Reset-phase ordering selected by MODE.
    if (MODE == MODE_FULL) begin : g_full
        assign drop_r = r_valid & r_ack;
        assign drop_a = ack_q & l_neutral;
    end else begin : g_half
        assign drop_r = r_valid & r_ack & l_neutral;
        assign drop_a = drop_r;
    end

    // State update for output rails and left acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rt_q  <= '0;
            rf_q  <= '0;
            ack_q <= 1'b0;
        end else if (fire) begin
            rt_q  <= l_t;
            rf_q  <= l_f;
            ack_q <= 1'b1;
        end else begin
            if (drop_r) begin
                rt_q <= '0;
                rf_q <= '0;
            end
            if (drop_a) ack_q <= 1'b0;
        end
    end

    assign r_t   = rt_q;
    assign r_f   = rf_q;
    assign l_ack = ack_q;
    assign occ   = r_valid & ~r_ack;

    // Output word never changes while valid and unacknowledged.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && !r_ack) |=> (r_t == $past(r_t) && r_f == $past(r_f)));

    // Output returns to neutral only after the right side acknowledged.
    assert_drop_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_valid) |-> $past(r_ack));

    // Acknowledge rises only for a complete word.
    assert_ack_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l_ack) |-> $past(l_valid));

    // Acknowledge falls only after the sender went neutral.
    assert_ack_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(l_ack) |-> $past(l_neutral));

    // No illegal rail pair is ever propagated.
    assert_no_illegal_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !r_bad);

    if (MODE == MODE_HALF) begin : g_half_chk
        // Half-buffer ordering: output clears only once input is neutral.
        assert_half_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(r_valid) |-> $past(l_neutral));
    end

endmodule

// File: rtl/dr_pipe.sv
// Module: top of the dual-rail pipeline emulator.
// Does: chains N_STAGES handshake stages, counts the words held and latches
// an illegal-rail error.
// Assumes: synchronous active-low reset; producer and consumer follow the
// four-phase return-to-zero protocol.
module dr_pipe
    import dr_pkg::*;
#(
    parameter int        N_STAGES = 4,
    parameter int        WIDTH    = 2,
    parameter buf_mode_e MODE     = MODE_HALF
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [WIDTH-1:0]                in_t,
    input  logic [WIDTH-1:0]                in_f,
    output logic                            in_ack,
    output logic [WIDTH-1:0]                out_t,
    output logic [WIDTH-1:0]                out_f,
    input  logic                            out_ack,
    output logic [N_STAGES-1:0]             occ,
    output logic [$clog2(N_STAGES+1)-1:0]   occ_count,
    output logic                            proto_err
);

    localparam int CW  = $clog2(N_STAGES + 1);
    localparam int CAP = (MODE == MODE_FULL) ? N_STAGES : N_STAGES / 2;

    logic [WIDTH-1:0]    ch_t [N_STAGES+1];
    logic [WIDTH-1:0]    ch_f [N_STAGES+1];
    logic [N_STAGES:0]   ack;
    logic [N_STAGES-1:0] bad;
    logic                err_q;

    assign ch_t[0]       = in_t;
    assign ch_f[0]       = in_f;
    assign ack[N_STAGES] = out_ack;

    // Stage chain.
    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
        dr_stage #(.WIDTH(WIDTH), .MODE(MODE)) u_st (
            .clk(clk), .rst_n(rst_n),
            .l_t(ch_t[s]), .l_f(ch_f[s]),
            .r_ack(ack[s+1]),
            .r_t(ch_t[s+1]), .r_f(ch_f[s+1]),
            .l_ack(ack[s]),
            .occ(occ[s]),
            .l_illegal(bad[s])
        );
    end

    assign in_ack = ack[0];
    assign out_t  = ch_t[N_STAGES];
    assign out_f  = ch_f[N_STAGES];

    // Token count: number of stages holding an unaccepted word.
    always_comb begin
        occ_count = '0;
        for (int i = 0; i < N_STAGES; i++) occ_count = occ_count + CW'(occ[i]);
    end

    // Sticky protocol error on any illegal rail pair.
    always_ff @(posedge clk) begin
        if (!rst_n)    err_q <= 1'b0;
        else if (|bad) err_q <= 1'b1;
    end

    assign proto_err = err_q;

    // Capacity bound set by the reset ordering.
    assert_capacity_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
        occ_count <= CW'(CAP));

    // Error flag never clears outside reset.
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(proto_err) |-> proto_err);

endmodule

// File: tb/sim_dr_pipe.sv
// Bench: drives one half-buffer and one full-buffer instance, with expected
// values computed from the requirements.
module sim_dr_pipe;
    import dr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int WD = 4;
    localparam int CW = $clog2(NS + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [WD-1:0] it [2];
    logic [WD-1:0] ifl [2];
    logic          oack [2];
    logic          iack [2];
    logic [WD-1:0] ot [2];
    logic [WD-1:0] of [2];
    logic [NS-1:0] occ [2];
    logic [CW-1:0] cnt [2];
    logic          err [2];

    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dr_pipe #(.N_STAGES(NS), .WIDTH(WD), .MODE(MODE_HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .in_t(it[0]), .in_f(ifl[0]), .in_ack(iack[0]),
        .out_t(ot[0]), .out_f(of[0]), .out_ack(oack[0]),
        .occ(occ[0]), .occ_count(cnt[0]), .proto_err(err[0]));

    dr_pipe #(.N_STAGES(NS), .WIDTH(WD), .MODE(MODE_FULL)) u1 (
        .clk(clk), .rst_n(rst_n), .in_t(it[1]), .in_f(ifl[1]), .in_ack(iack[1]),
        .out_t(ot[1]), .out_f(of[1]), .out_ack(oack[1]),
        .occ(occ[1]), .occ_count(cnt[1]), .proto_err(err[1]));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    endtask

    function automatic logic [WD-1:0] word(input int i);
        return WD'((i * 7 + 3) % (1 << WD));
    endfunction

    function automatic bit out_valid(input int m);
        return (ot[m] ^ of[m]) == '1;
    endfunction

    function automatic bit out_neutral(input int m);
        return ot[m] == '0 && of[m] == '0;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int m = 0; m < 2; m++) begin
            it[m] = '0; ifl[m] = '0; oack[m] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Streams ntok words; consumer starts acknowledging at cycle stall.
    task automatic stream(input int m, input int ntok, input int stall);
        int sent = 0, ph = 0, rcv = 0, cyc = 0, maxo = 0;
        int bad_stab = 0, bad_cnt = 0;
        logic [WD-1:0] hold = '0;
        bit holding = 0;
        int cap = (m == 1) ? NS : NS / 2;
        do_reset();
        it[m] = word(0); ifl[m] = ~word(0);
        while (rcv < ntok && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            if (int'(cnt[m]) > maxo) maxo = int'(cnt[m]);
            if (int'(cnt[m]) != $countones(occ[m])) bad_cnt++;
            if (stall > 0 && cyc == stall)
                chk(occ[m] == ((m == 1) ? 4'b1111 : 4'b1010),
                    (m == 1) ? "R6 stalled occ pattern" : "R5 stalled occ pattern",
                    int'(occ[m]), (m == 1) ? 15 : 10);
            // R9: output stable while unacknowledged
            if (!out_valid(m)) holding = 0;
            else if (!oack[m]) begin
                if (holding && ot[m] != hold) bad_stab++;
                hold = ot[m];
                holding = 1;
            end
            // consumer
            if (cyc >= stall) begin
                if (!oack[m] && out_valid(m)) begin
                    chk(ot[m] == word(rcv), "R2 order/data", int'(ot[m]), int'(word(rcv)));
                    rcv++;
                    oack[m] = 1'b1;
                end else if (oack[m] && out_neutral(m)) begin
                    oack[m] = 1'b0;
                end
            end
            // producer
            if (sent < ntok) begin
                if (ph == 0 && iack[m]) begin
                    it[m] = '0; ifl[m] = '0; ph = 1;
                end else if (ph == 1 && !iack[m]) begin
                    sent++;
                    ph = 0;
                    if (sent < ntok) begin
                        it[m] = word(sent); ifl[m] = ~word(sent);
                    end
                end
            end
        end
        chk(rcv == ntok, "R2 all words delivered", rcv, ntok);
        chk(bad_stab == 0, "R9 output stability", bad_stab, 0);
        chk(bad_cnt == 0, "R7 count matches occ bits", bad_cnt, 0);
        if (stall > 0)
            chk(maxo == cap, (m == 1) ? "R6 max occupancy" : "R5 max occupancy", maxo, cap);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        for (int m = 0; m < 2; m++) begin
            it[m] = '0; ifl[m] = '0; oack[m] = 1'b0;
        end
        do_reset();
        @(negedge clk);
        // R1: reset state
        for (int m = 0; m < 2; m++) begin
            chk(out_neutral(m), "R1 output rails neutral", int'(ot[m] | of[m]), 0);
            chk(!iack[m], "R1 in_ack low", int'(iack[m]), 0);
            chk(occ[m] == '0 && cnt[m] == '0, "R1 occupancy zero", int'(cnt[m]), 0);
            chk(!err[m], "R1 proto_err low", int'(err[m]), 0);
        end

        // R10: latency through an empty pipeline
        for (int m = 0; m < 2; m++) begin
            do_reset();
            it[m] = 4'hA; ifl[m] = 4'h5;
            for (int k = 1; k <= NS; k++) begin
                @(negedge clk);
                if (k == NS - 1) chk(out_neutral(m), "R10 not yet at output", int'(ot[m]), 0);
                if (k == NS) chk(out_valid(m) && ot[m] == 4'hA, "R10 arrives after N edges",
                                 int'(ot[m]), 10);
            end
        end

        // R3 partial word, then R4 handshake timing
        for (int m = 0; m < 2; m++) begin
            int held_bad = 0;
            int waited = 0;
            do_reset();
            it[m] = 4'b0001; ifl[m] = 4'b0000;
            repeat (3) @(negedge clk);
            chk(!iack[m] && cnt[m] == '0, "R3 partial word not accepted", int'(iack[m]), 0);
            it[m] = 4'b0101; ifl[m] = 4'b1010;
            @(negedge clk);
            chk(iack[m], "R3 complete word acknowledged", int'(iack[m]), 1);
            repeat (3) begin
                @(negedge clk);
                if (!iack[m]) held_bad++;
            end
            chk(held_bad == 0, "R4 ack held while input valid", held_bad, 0);
            it[m] = '0; ifl[m] = '0;
            while (iack[m] && waited < 6) begin
                @(negedge clk);
                waited++;
            end
            chk(!iack[m], "R4 ack falls after neutral", int'(iack[m]), 0);
        end

        // R8: illegal rail pair on bit 1
        for (int m = 0; m < 2; m++) begin
            do_reset();
            it[m] = 4'b1010; ifl[m] = 4'b0111;
            @(negedge clk);
            chk(err[m], "R8 error raised", int'(err[m]), 1);
            repeat (2) @(negedge clk);
            chk(!iack[m] && cnt[m] == '0, "R8 illegal word not accepted", int'(iack[m]), 0);
            it[m] = '0; ifl[m] = '0;
            repeat (2) @(negedge clk);
            chk(err[m], "R8 error sticky", int'(err[m]), 1);
            do_reset();
            @(negedge clk);
            chk(!err[m], "R8 error cleared by reset", int'(err[m]), 0);
        end

        // Sweep all 16 values, free-flowing and with a stalled consumer
        for (int m = 0; m < 2; m++) begin
            stream(m, 16, 0);
            stream(m, 16, 40);
        end

        finish_run();
    end

endmodule